// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block sits between an instruction byte source and an execution stage. It accepts one byte per valid/ready handshake, finds where each instruction begins and ends, and emits one decoded record per instruction. A record carries the 16-bit opcode, the operand class of that opcode, and, for each of up to two operands, the 4-bit mode code, the operand kind, the width of the value it names, and the collected value. The value is an address, a register index or an immediate. The record also carries the total length in bytes and an invalid flag, which the consumer can turn into the invalid-opcode exception (vector 1).

An instruction is a 2-byte opcode, sent low byte first. All opcodes except those with no operands are followed by a mode byte. Operand bytes come after the mode byte, first parameter first. An address operand is `VAL_W/8` bytes. A register operand is one byte. An immediate is as many bytes as its own width. Every multi-byte value arrives least significant byte first. The record is presented only after its last byte has arrived, and it stays on the outputs until the consumer takes it. No input byte is accepted while a record is waiting.

Top module: `insn_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Opcodes 0x3001, 0x3005 and 0xF000 to 0xF002 produce a record after two bytes, with class 0 (none), length 2, invalid 0, and both operand kinds 3 (none).
- R3: The first byte of an instruction is bits 7:0 of `out_opcode` and the second byte is bits 15:8.
- R4: `out_class` follows the opcode. 0x1000 to 0x100C give 3 (destination, source). 0x2000, 0x2001 and 0x3004 give 4 (source, source). 0x2002 to 0x2004, 0x3000 and 0x3002 give 1 (one source). 0x3003 gives 2 (one destination). 0x4000 gives 5 (source, destination). The no-operand set gives 0.
- R5: Operand slot 0 is the first parameter. Its mode comes from the upper nibble of the mode byte, except in class 5, where it comes from the lower nibble and slot 1 takes the upper nibble. In classes 3 and 4, slot 1 takes the lower nibble. In classes 1 and 2, slot 1 is unused: its mode is 0 and its kind is 3.
- R6: Mode codes 0 to 3 give kind 0 (address), with 8 bytes of operand and widths 8, 4, 2 and 1. Mode 4 gives kind 1 (register), with 1 byte and width 8. Modes 5 to 8 give kind 2 (immediate), with widths and byte counts 8, 4, 2 and 1. Modes 9 to 15 give kind 3. Operand values are assembled little-endian and zero-extended.
- R7: A register operand's value is its byte's bits 5:0. If bits 7:6 of that byte are not zero, `out_invalid` is 1, and the record still spans every operand byte.
- R8: A mode code of 9 to 15, an immediate mode (5 to 8) in a destination slot, or a nonzero lower nibble in a one-operand mode byte sets `out_invalid`. The record is emitted right after the mode byte, with length 3.
- R9: Any opcode outside R4's sets gives class 7 and `out_invalid` 1, and the record is emitted after two bytes with length 2.
- R10: While `out_valid` is 1 and `out_ready` is 0, the record stays unchanged and `in_ready` is 0. Bytes offered in that time are not consumed.
- R11: `out_len` equals the number of bytes the instruction consumed. `out_valid` rises in the cycle after the last byte is accepted and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | Decoded record is presented |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 16 | Opcode |
| out_class | output | 3 | Operand class code |
| out_mode0 | output | 4 | Mode code of first operand |
| out_kind0 | output | 2 | Kind of first operand |
| out_width0 | output | WID_W | Value width of first operand, bytes |
| out_value0 | output | VAL_W | Address, register index or immediate of first operand |
| out_mode1 | output | 4 | Mode code of second operand |
| out_kind1 | output | 2 | Kind of second operand |
| out_width1 | output | WID_W | Value width of second operand, bytes |
| out_value1 | output | VAL_W | Value of second operand |
| out_len | output | LEN_W | Instruction length in bytes |
| out_invalid | output | 1 | Illegal opcode, mode or register byte |

## Verification
The bench builds the decoder with the default `VAL_W` of 64, so an address operand is 8 bytes. This makes the longest legal instruction (0x4000 with an address destination and a 64-bit immediate source) 19 bytes, which fills the 5-bit length and the upper byte lanes of both value fields. With this width, all sixteen mode codes and every opcode class, including the early-terminated illegal forms, can be reached. Records are checked against a model computed from the opcode and the mode byte. Random gaps on the input and random stalls on the output exercise the hold behaviour.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

    typedef enum logic [2:0] {
        CLS_NONE    = 3'd0,
        CLS_SRC     = 3'd1,
        CLS_DST     = 3'd2,
        CLS_DST_SRC = 3'd3,
        CLS_SRC_SRC = 3'd4,
        CLS_SRC_DST = 3'd5,
        CLS_BAD     = 3'd7
    } opd_class_e;

    typedef enum logic [1:0] {
        KIND_ADDR = 2'd0,
        KIND_REG  = 2'd1,
        KIND_IMM  = 2'd2,
        KIND_NONE = 2'd3
    } opd_kind_e;

    typedef enum logic [2:0] {
        ST_OPC_LO = 3'd0,
        ST_OPC_HI = 3'd1,
        ST_MODE   = 3'd2,
        ST_OPND   = 3'd3,
        ST_EMIT   = 3'd4
    } dec_state_e;

endpackage

// File: rtl/idec_class.sv
module idec_class
    import insn_dec_pkg::*;
(
    input  logic [15:0] opc,
    output opd_class_e  cls
);
    always_comb begin
        if (opc inside {[16'h1000:16'h100C]})
            cls = CLS_DST_SRC;
        else if (opc inside {16'h2000, 16'h2001, 16'h3004})
            cls = CLS_SRC_SRC;
        else if (opc inside {[16'h2002:16'h2004], 16'h3000, 16'h3002})
            cls = CLS_SRC;
        else if (opc == 16'h3003)
            cls = CLS_DST;
        else if (opc == 16'h4000)
            cls = CLS_SRC_DST;
        else if (opc inside {16'h3001, 16'h3005, [16'hF000:16'hF002]})
            cls = CLS_NONE;
        else
            cls = CLS_BAD;
    end
endmodule

// File: rtl/idec_mode.sv
module idec_mode
    import insn_dec_pkg::*;
#(
    parameter int ADDR_BYTES = 8,
    parameter int WID_W      = 4
) (
    input  logic [3:0]       mode,
    output opd_kind_e        kind,
    output logic [WID_W-1:0] width,
    output logic [WID_W-1:0] nbytes,
    output logic             legal_src,
    output logic             legal_dst
);
    always_comb begin
        kind   = KIND_NONE;
        width  = '0;
        nbytes = '0;
        if (mode <= 4'd3) begin
            kind   = KIND_ADDR;
            width  = WID_W'(ADDR_BYTES >> mode[1:0]);
            nbytes = WID_W'(ADDR_BYTES);
        end else if (mode == 4'd4) begin
            kind   = KIND_REG;
            width  = WID_W'(ADDR_BYTES);
            nbytes = WID_W'(1);
        end else if (mode <= 4'd8) begin
            kind   = KIND_IMM;
            width  = WID_W'(ADDR_BYTES >> (mode - 4'd5));
            nbytes = WID_W'(ADDR_BYTES >> (mode - 4'd5));
        end
        legal_src = (mode <= 4'd8);
        legal_dst = (mode <= 4'd4);
    end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
    import insn_dec_pkg::*;
#(
    parameter  int VAL_W      = 64,
    localparam int ADDR_BYTES = VAL_W / 8,
    localparam int WID_W      = $clog2(ADDR_BYTES + 1),
    localparam int CNT_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
    localparam int LEN_W      = $clog2(3 + 2 * ADDR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_byte,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [15:0]      out_opcode,
    output logic [2:0]       out_class,
    output logic [3:0]       out_mode0,
    output logic [1:0]       out_kind0,
    output logic [WID_W-1:0] out_width0,
    output logic [VAL_W-1:0] out_value0,
    output logic [3:0]       out_mode1,
    output logic [1:0]       out_kind1,
    output logic [WID_W-1:0] out_width1,
    output logic [VAL_W-1:0] out_value1,
    output logic [LEN_W-1:0] out_len,
    output logic             out_invalid
);

    typedef struct packed {
        dec_state_e             st;
        logic [15:0]            opc;
        opd_class_e             cls;
        logic [1:0][3:0]        mode;
        logic [1:0]             nops;
        logic                   idx;
        logic [CNT_W-1:0]       cnt;
        logic [1:0][VAL_W-1:0]  val;
        logic [LEN_W-1:0]       len;
        logic                   inv;
    } dec_reg_t;

    dec_reg_t q, d;

    opd_class_e       new_cls;
    logic [3:0]       hi_nib, lo_nib;
    logic [1:0][3:0]  arr, dec_in;
    opd_kind_e        kind [2];
    logic [WID_W-1:0] width [2];
    logic [WID_W-1:0] nbytes [2];
    logic [1:0]       lsrc, ldst, is_dst, slot_ok;
    logic             single, mode_ok, accept;
    logic [7:0]       opnd_byte;
    logic [VAL_W-1:0] shifted;
    logic [WID_W-1:0] cur_n;

    // opcode class looks at the incoming high byte joined to the stored low byte
    idec_class u_class (
        .opc ({in_byte, q.opc[7:0]}),
        .cls (new_cls)
    );

    generate
        for (genvar gi = 0; gi < 2; gi++) begin : g_mode
            idec_mode #(
                .ADDR_BYTES (ADDR_BYTES),
                .WID_W      (WID_W)
            ) u_mode (
                .mode      (dec_in[gi]),
                .kind      (kind[gi]),
                .width     (width[gi]),
                .nbytes    (nbytes[gi]),
                .legal_src (lsrc[gi]),
                .legal_dst (ldst[gi])
            );
        end
    endgenerate

    // place mode nibbles into parameter-order slots
    always_comb begin
        hi_nib = in_byte[7:4];
        lo_nib = in_byte[3:0];
        case (q.cls)
            CLS_SRC_DST:              arr = {hi_nib, lo_nib};
            CLS_DST_SRC, CLS_SRC_SRC: arr = {lo_nib, hi_nib};
            default:                  arr = {4'h0, hi_nib};
        endcase
        dec_in    = (q.st == ST_MODE) ? arr : q.mode;
        is_dst[0] = (q.cls == CLS_DST_SRC) || (q.cls == CLS_DST);
        is_dst[1] = (q.cls == CLS_SRC_DST);
        single    = (q.cls == CLS_SRC) || (q.cls == CLS_DST);
        for (int i = 0; i < 2; i++)
            slot_ok[i] = is_dst[i] ? ldst[i] : lsrc[i];
        mode_ok = single ? (slot_ok[0] && (lo_nib == 4'h0)) : (&slot_ok);
    end

    always_comb begin
        d         = q;
        accept    = in_valid && (q.st != ST_EMIT);
        cur_n     = nbytes[q.idx];
        opnd_byte = (kind[q.idx] == KIND_REG) ? {2'b00, in_byte[5:0]} : in_byte;
        shifted   = {{(VAL_W-8){1'b0}}, opnd_byte} << {q.cnt, 3'b000};
        case (q.st)
            ST_OPC_LO: if (accept) begin
                d      = '0;
                d.opc  = {8'h00, in_byte};
                d.len  = LEN_W'(1);
                d.st   = ST_OPC_HI;
            end
            ST_OPC_HI: if (accept) begin
                d.opc[15:8] = in_byte;
                d.cls       = new_cls;
                d.len       = LEN_W'(2);
                if (new_cls == CLS_NONE) begin
                    d.st = ST_EMIT;
                end else if (new_cls == CLS_BAD) begin
                    d.inv = 1'b1;
                    d.st  = ST_EMIT;
                end else begin
                    d.st = ST_MODE;
                end
            end
            ST_MODE: if (accept) begin
                d.len  = LEN_W'(3);
                d.mode = arr;
                d.nops = single ? 2'd1 : 2'd2;
                if (!mode_ok) begin
                    d.inv = 1'b1;
                    d.st  = ST_EMIT;
                end else begin
                    d.st = ST_OPND;
                end
            end
            ST_OPND: if (accept) begin
                d.len        = q.len + 1'b1;
                d.val[q.idx] = q.val[q.idx] | shifted;
                if ((kind[q.idx] == KIND_REG) && (in_byte[7:6] != 2'b00))
                    d.inv = 1'b1;
                if (WID_W'(q.cnt) + WID_W'(1) == cur_n) begin
                    d.cnt = '0;
                    if (2'(q.idx) + 2'd1 == q.nops)
                        d.st = ST_EMIT;
                    else
                        d.idx = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_EMIT: if (out_ready) d.st = ST_OPC_LO;
            default: d.st = ST_OPC_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready    = (q.st != ST_EMIT);
    assign out_valid   = (q.st == ST_EMIT);
    assign out_opcode  = q.opc;
    assign out_class   = q.cls;
    assign out_len     = q.len;
    assign out_invalid = q.inv;
    assign out_mode0   = q.mode[0];
    assign out_mode1   = q.mode[1];
    assign out_value0  = q.val[0];
    assign out_value1  = q.val[1];
    assign out_kind0   = (q.nops > 2'd0) ? kind[0]  : KIND_NONE;
    assign out_kind1   = (q.nops > 2'd1) ? kind[1]  : KIND_NONE;
    assign out_width0  = (q.nops > 2'd0) ? width[0] : '0;
    assign out_width1  = (q.nops > 2'd1) ? width[1] : '0;

endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk #(
    parameter  int VAL_W      = 64,
    localparam int ADDR_BYTES = VAL_W / 8,
    localparam int WID_W      = $clog2(ADDR_BYTES + 1),
    localparam int LEN_W      = $clog2(3 + 2 * ADDR_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [7:0]       in_byte,
    input logic             out_valid,
    input logic             out_ready,
    input logic [15:0]      out_opcode,
    input logic [2:0]       out_class,
    input logic [3:0]       out_mode0,
    input logic [1:0]       out_kind0,
    input logic [WID_W-1:0] out_width0,
    input logic [VAL_W-1:0] out_value0,
    input logic [3:0]       out_mode1,
    input logic [1:0]       out_kind1,
    input logic [WID_W-1:0] out_width1,
    input logic [VAL_W-1:0] out_value1,
    input logic [LEN_W-1:0] out_len,
    input logic             out_invalid
);
    localparam int MAX_LEN = 3 + 2 * ADDR_BYTES;

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));

    assert_record_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) && $stable(out_len)
            && $stable(out_value0) && $stable(out_value1) && $stable(out_invalid)
            && $stable(out_class)));

    assert_no_take_while_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_short_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 3'd0) |-> (out_len == 2 && !out_invalid && out_kind0 == 2'd3));

    assert_bad_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 3'd7) |-> (out_invalid && out_len == 2));

    assert_single_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_class == 3'd1 || out_class == 3'd2)) |-> (out_kind1 == 2'd3));

    assert_dst_not_imm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_invalid && out_class == 3'd3) |-> (out_kind0 != 2'd2));

    assert_len_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= 2 && out_len <= MAX_LEN));

endmodule

bind insn_decoder insn_decoder_chk #(.VAL_W(VAL_W)) u_chk (.*);

// File: tb/insn_decoder_tb.sv
module insn_decoder_tb;
    localparam int VAL_W = 64;
    localparam int AB    = VAL_W / 8;
    localparam int WID_W = $clog2(AB + 1);
    localparam int LEN_W = $clog2(3 + 2 * AB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic             in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
    logic [7:0]       in_byte = 8'h00;
    logic [15:0]      out_opcode;
    logic [2:0]       out_class;
    logic [3:0]       out_mode0, out_mode1;
    logic [1:0]       out_kind0, out_kind1;
    logic [WID_W-1:0] out_width0, out_width1;
    logic [VAL_W-1:0] out_value0, out_value1;
    logic [LEN_W-1:0] out_len;
    logic             out_invalid;

    insn_decoder #(.VAL_W(VAL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
        .out_opcode(out_opcode), .out_class(out_class),
        .out_mode0(out_mode0), .out_kind0(out_kind0), .out_width0(out_width0),
        .out_value0(out_value0), .out_mode1(out_mode1), .out_kind1(out_kind1),
        .out_width1(out_width1), .out_value1(out_value1),
        .out_len(out_len), .out_invalid(out_invalid)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [VAL_W-1:0] act, input logic [VAL_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // expected record
    logic [7:0]       sb [0:31];
    int               sn;
    logic [15:0]      e_opc;
    int               e_cls;
    logic [3:0]       e_mode [2];
    int               e_kind [2];
    int               e_width [2];
    logic [VAL_W-1:0] e_val [2];
    int               e_len;
    bit               e_inv;
    string            e_invtag;

    localparam logic [15:0] OPS [23] = '{
        16'h1000, 16'h1001, 16'h1002, 16'h1003, 16'h1004, 16'h1005, 16'h1006,
        16'h1007, 16'h1008, 16'h1009, 16'h100A, 16'h100B, 16'h100C,
        16'h2000, 16'h2001, 16'h2002, 16'h2003, 16'h2004,
        16'h3000, 16'h3002, 16'h3003, 16'h3004, 16'h4000 };

    function automatic int ref_class(input logic [15:0] o);
        if (o >= 16'h1000 && o <= 16'h100C) return 3;
        if (o == 16'h2000 || o == 16'h2001 || o == 16'h3004) return 4;
        if ((o >= 16'h2002 && o <= 16'h2004) || o == 16'h3000 || o == 16'h3002) return 1;
        if (o == 16'h3003) return 2;
        if (o == 16'h4000) return 5;
        if (o == 16'h3001 || o == 16'h3005 || (o >= 16'hF000 && o <= 16'hF002)) return 0;
        return 7;
    endfunction

    function automatic int ref_kind(input int m);
        if (m <= 3) return 0;
        if (m == 4) return 1;
        if (m <= 8) return 2;
        return 3;
    endfunction

    function automatic int ref_width(input int m);
        if (m <= 3) return AB >> m;
        if (m == 4) return AB;
        if (m <= 8) return AB >> (m - 5);
        return 0;
    endfunction

    function automatic int ref_nbytes(input int m);
        if (m <= 3) return AB;
        if (m == 4) return 1;
        return ref_width(m);
    endfunction

    function automatic bit slot_is_dst(input int cls, input int slot);
        return (cls == 3 && slot == 0) || (cls == 2 && slot == 0) || (cls == 5 && slot == 1);
    endfunction

    task automatic build(input logic [15:0] opc, input logic [7:0] mbyte, input bit regbad);
        int nops;
        int p [2];
        bit bad;
        logic [3:0] hi, lo;
        sn = 0;
        sb[sn++] = opc[7:0];
        sb[sn++] = opc[15:8];
        e_opc = opc;
        e_cls = ref_class(opc);
        for (int i = 0; i < 2; i++) begin
            e_mode[i] = 4'h0; e_kind[i] = 3; e_width[i] = 0; e_val[i] = '0;
        end
        e_inv = 1'b0;
        e_invtag = "R4";
        e_len = 2;
        if (e_cls == 7) begin
            e_inv = 1'b1; e_invtag = "R9";
            return;
        end
        if (e_cls == 0) begin
            e_invtag = "R2";
            return;
        end
        sb[sn++] = mbyte;
        hi = mbyte[7:4];
        lo = mbyte[3:0];
        nops = (e_cls == 1 || e_cls == 2) ? 1 : 2;
        if (e_cls == 5) begin p[0] = int'(lo); p[1] = int'(hi); end
        else if (nops == 2) begin p[0] = int'(hi); p[1] = int'(lo); end
        else begin p[0] = int'(hi); p[1] = 0; end
        bad = (nops == 1) && (lo != 4'h0);
        for (int i = 0; i < nops; i++) begin
            e_mode[i]  = 4'(p[i]);
            e_kind[i]  = ref_kind(p[i]);
            e_width[i] = ref_width(p[i]);
            if (p[i] > 8) bad = 1'b1;
            if (slot_is_dst(e_cls, i) && p[i] >= 5) bad = 1'b1;
        end
        if (bad) begin
            e_inv = 1'b1; e_invtag = "R8"; e_len = 3;
            return;
        end
        for (int i = 0; i < nops; i++) begin
            if (e_kind[i] == 1) begin
                logic [7:0] b;
                b[5:0] = 6'($urandom);
                b[7:6] = regbad ? 2'(1 + $urandom % 3) : 2'b00;
                if (regbad) begin e_inv = 1'b1; e_invtag = "R7"; end
                e_val[i] = VAL_W'(b[5:0]);
                sb[sn++] = b;
            end else begin
                for (int k = 0; k < ref_nbytes(p[i]); k++) begin
                    logic [7:0] b;
                    b = 8'($urandom);
                    e_val[i] = e_val[i] | (VAL_W'(b) << (8 * k));
                    sb[sn++] = b;
                end
            end
        end
        e_len = sn;
    endtask

    task automatic compare(input string ctx);
        string ctag;
        ctag = (e_cls == 0) ? "R2" : ((e_cls == 7) ? "R9" : "R4");
        chk("R3",  {ctx, " opcode"}, VAL_W'(out_opcode), VAL_W'(e_opc));
        chk(ctag,  {ctx, " class"},  VAL_W'(out_class),  VAL_W'(e_cls));
        chk("R5",  {ctx, " modes"},  VAL_W'({out_mode1, out_mode0}), VAL_W'({e_mode[1], e_mode[0]}));
        chk("R6",  {ctx, " kinds"},  VAL_W'({out_kind1, out_kind0}), VAL_W'({2'(e_kind[1]), 2'(e_kind[0])}));
        chk("R6",  {ctx, " widths"}, VAL_W'({out_width1, out_width0}),
            VAL_W'({WID_W'(e_width[1]), WID_W'(e_width[0])}));
        chk("R6",  {ctx, " value0"}, out_value0, e_val[0]);
        chk("R6",  {ctx, " value1"}, out_value1, e_val[1]);
        chk("R11", {ctx, " length"}, VAL_W'(out_len), VAL_W'(e_len));
        chk(e_invtag, {ctx, " invalid"}, VAL_W'(out_invalid), VAL_W'(e_inv));
    endtask

    // drive exactly sn bytes, then check, stall and release the record
    task automatic run_one(input string ctx);
        int stall;
        for (int k = 0; k < sn; k++) begin
            repeat ($urandom % 3) @(negedge clk);
            chk("R11", {ctx, " early valid"}, VAL_W'(out_valid), '0);
            in_valid = 1'b1;
            in_byte  = sb[k];
            @(negedge clk);
            in_valid = 1'b0;
        end
        chk("R11", {ctx, " valid after last byte"}, VAL_W'(out_valid), VAL_W'(1));
        compare(ctx);
        stall = $urandom % 4;
        in_valid = (stall != 0);
        in_byte  = 8'(8'hF0 + stall);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk("R10", {ctx, " held valid"}, VAL_W'({out_valid, in_ready}), VAL_W'(2'b10));
            chk("R10", {ctx, " held length"}, VAL_W'(out_len), VAL_W'(e_len));
            chk("R10", {ctx, " held value0"}, out_value0, e_val[0]);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b0;
        chk("R10", {ctx, " released"}, VAL_W'(out_valid), '0);
    endtask

    function automatic logic [3:0] pick_mode(input bit dst);
        if ($urandom % 100 < 90) return dst ? 4'($urandom % 5) : 4'($urandom % 9);
        return 4'($urandom % 16);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1", "reset outputs", VAL_W'({out_valid, in_ready}), VAL_W'(2'b01));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "after reset", VAL_W'({out_valid, in_ready}), VAL_W'(2'b01));

        // directed corners
        build(16'hF001, 8'h00, 1'b0); run_one("nop R2");
        build(16'h3005, 8'h00, 1'b0); run_one("no-operand R2");
        build(16'h4000, 8'h05, 1'b0); run_one("longest R5");
        build(16'h1000, 8'h54, 1'b0); run_one("imm dst R8");
        build(16'h3003, 8'h80, 1'b0); run_one("pop imm R8");
        build(16'h2002, 8'h49, 1'b0); run_one("low nibble R8");
        build(16'h2000, 8'h93, 1'b0); run_one("mode9 R8");
        build(16'h100D, 8'h00, 1'b0); run_one("bad opcode R9");
        build(16'h0000, 8'h00, 1'b0); run_one("zero opcode R9");
        build(16'h1002, 8'h44, 1'b1); run_one("reg upper bits R7");
        build(16'h3004, 8'h86, 1'b0); run_one("two imm R6");
        build(16'h2004, 8'h30, 1'b0); run_one("addr byte R6");
        build(16'h4000, 8'h48, 1'b0); run_one("mov reg R5");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [15:0] opc;
            logic [7:0]  mb;
            int          cls;
            opc = ($urandom % 100 < 8) ? 16'($urandom) : OPS[$urandom % 23];
            if ($urandom % 100 < 5) opc = ($urandom % 2) ? 16'hF000 : 16'h3001;
            cls = ref_class(opc);
            case (cls)
                3: mb = {pick_mode(1'b1), pick_mode(1'b0)};
                4: mb = {pick_mode(1'b0), pick_mode(1'b0)};
                5: mb = {pick_mode(1'b1), pick_mode(1'b0)};
                1: mb = {pick_mode(1'b0), ($urandom % 20 == 0) ? 4'($urandom) : 4'h0};
                2: mb = {pick_mode(1'b1), ($urandom % 20 == 0) ? 4'($urandom) : 4'h0};
                default: mb = 8'h00;
            endcase
            build(opc, mb, ($urandom % 20 == 0));
            run_one("random");
        end
        finish_run();
    end
endmodule